// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps one processor's cache coherent with its peers on a shared snooping bus. A small direct-mapped array holds, for every line, a tag, a data word and two permission bits: one marks a line that may be read alongside other caches (shared), the other marks a line this cache owns alone (exclusive). Local accesses that find enough permission finish in the cycle they are presented. Otherwise the controller places one request on the bus, asking for either shared or exclusive (locked) access, and fills the line when the bus grants it.

At the same time the controller watches every request another processor places on the bus. When it holds the requested line, it raises a hit, drives the line's data so that the memory read can be skipped, and adjusts its own bits. A shared request demotes its copy to shared. An exclusive request removes its copy. While its own processor holds a lock on the requested line, it raises a stall that keeps the requester waiting until the lock ends. Outside the block, the bus's hit and stall are the OR of every snooper's outputs, and the bus data comes from the hitting cache or, with no hit, from memory.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: Each line's permission pair is invalid (neither bit), shared only, or exclusive only; no line ever has both bits set.
- R2: A local read on a shared or exclusive line, or a local exclusive access on an exclusive line, raises cpu_done in the same cycle as cpu_req_valid and places no request on the bus.
- R3: A local access that misses places a request (req_valid, req_addr, req_excl = cpu_req_excl, req_id = MY_ID) on the bus from the next cycle on. The line fills at the granting clock edge and cpu_done follows one cycle later, two cycles after the access was first presented when no stall occurs.
- R4: When another processor's request hits a valid line here, snp_hit rises and snp_data carries this cache's copy, so the requester receives that copy instead of memory contents.
- R5: On a snooped shared request that is not stalled, the holder keeps the line with the shared bit only, and the requester installs it with the shared bit only.
- R6: On a snooped exclusive request that is not stalled, the holder invalidates the line, and the requester installs it with the exclusive bit only, so later exclusive accesses there hit at once.
- R7: When no cache holds the line, the requester installs the memory word carried on bus_data.
- R8: An exclusive access to a line held shared issues an exclusive upgrade request, which invalidates every other copy.
- R9: While cpu_lock is high, cpu_req_addr equals the snooped address and this cache holds that line exclusively, snp_stall is raised. The requester keeps waiting and neither side changes state until the lock drops.
- R10: When a snoop update and a local hit fall on the same line in the same cycle, the snoop takes effect and cpu_done is withheld in that cycle. The local access then proceeds on the updated state.
- R11: A controller never answers a bus request that carries its own ID.
- R12: A local write (cpu_req_we with cpu_req_excl) that completes on an exclusive line stores cpu_wdata. Later local reads and later peer requests see that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Local access presented, held until cpu_done |
| cpu_req_addr | input | AW | Local line address; also names the locked line while cpu_lock is high |
| cpu_req_excl | input | 1 | Local access needs exclusive (locked) permission |
| cpu_req_we | input | 1 | Local access writes cpu_wdata (only with cpu_req_excl) |
| cpu_wdata | input | DW | Local write data |
| cpu_lock | input | 1 | Local locked operation in progress on cpu_req_addr |
| cpu_done | output | 1 | Local access completes this cycle |
| cpu_rdata | output | DW | Line data for the completing access |
| req_valid | output | 1 | Bus request from this controller |
| req_addr | output | AW | Requested line address |
| req_excl | output | 1 | 1 requests exclusive access, 0 requests shared access |
| req_id | output | ID_W | This controller's ID |
| bus_valid | input | 1 | Request on the bus this cycle |
| bus_addr | input | AW | Address of the bus request |
| bus_excl | input | 1 | Type of the bus request |
| bus_id | input | ID_W | Requester ID of the bus request |
| bus_stall | input | 1 | OR of all snooper stalls |
| bus_data | input | DW | Line data from the hitting cache or from memory |
| snp_hit | output | 1 | This cache holds the line another processor requests |
| snp_stall | output | 1 | This cache holds off the current request |
| snp_data | output | DW | This cache's copy when snp_hit, zero otherwise |

## Verification
The hazardous overlap is a local hit and a snoop update on the same line in one cycle, for example a peer's exclusive request arriving just as the owning processor reads the line. The bench provokes it by starting the peer's exclusive write one cycle before the owner's read of the line it holds exclusively, so the peer's bus request meets the owner's read. The outcome is judged at the ports. The owner must not complete in the colliding cycle and must take exactly three cycles. Its data must be the value the peer wrote, which shows that the invalidation won and the read was served from the new owner.

// File: rtl/coh_pkg.sv
package coh_pkg;

  // Permission pair of one cache line: shr = shared copy, exc = exclusive owner.
  typedef struct packed {
    logic shr;
    logic exc;
  } line_bits_t;

  localparam line_bits_t LB_INV = '{shr: 1'b0, exc: 1'b0};
  localparam line_bits_t LB_SHR = '{shr: 1'b1, exc: 1'b0};
  localparam line_bits_t LB_EXC = '{shr: 1'b0, exc: 1'b1};

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } req_st_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // local lookup / fill / write port
  input  logic [AW-1:0]             cpu_addr,
  output logic                      cpu_tag_hit,
  output line_bits_t                cpu_bits,
  output logic [DW-1:0]             cpu_data,
  input  logic                      fill_en,
  input  line_bits_t                fill_bits,
  input  logic [DW-1:0]             fill_data,
  input  logic                      wr_en,
  input  logic [DW-1:0]             wr_data,
  // snoop lookup / update port
  input  logic [AW-1:0]             snp_addr,
  output logic                      snp_tag_hit,
  output line_bits_t                snp_bits,
  output logic [DW-1:0]             snp_data,
  input  logic                      snp_upd_en,
  input  line_bits_t                snp_upd_bits,
  // all permission pairs, for checking
  output logic [2*(1<<IDX_W)-1:0]   bits_flat
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W;

  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];
  line_bits_t       bits_q [LINES];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[AW-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[AW-1:IDX_W];

  always_comb begin
    cpu_bits    = bits_q[cpu_idx];
    cpu_data    = data_q[cpu_idx];
    cpu_tag_hit = (|bits_q[cpu_idx]) && (tag_q[cpu_idx] == cpu_tag);
    snp_bits    = bits_q[snp_idx];
    snp_data    = data_q[snp_idx];
    snp_tag_hit = (|bits_q[snp_idx]) && (tag_q[snp_idx] == snp_tag);
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] LINE_IDX = IDX_W'(g);
    logic sel_cpu, sel_snp;
    assign sel_cpu = (cpu_idx == LINE_IDX);
    assign sel_snp = (snp_idx == LINE_IDX);

    // permission bits: fill (own grant) and snoop update never share a cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[g] <= LB_INV;
      end else if (fill_en && sel_cpu) begin
        bits_q[g] <= fill_bits;
      end else if (snp_upd_en && sel_snp) begin
        bits_q[g] <= snp_upd_bits;
      end
    end

    // tag and data need no reset: they are qualified by the bits
    always_ff @(posedge clk) begin
      if (fill_en && sel_cpu) begin
        tag_q[g]  <= cpu_tag;
        data_q[g] <= fill_data;
      end else if (wr_en && sel_cpu) begin
        data_q[g] <= wr_data;
      end
    end

    assign bits_flat[2*g +: 2] = bits_q[g];

    assert_bits_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bits_q[g].shr && bits_q[g].exc));
  end

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int ID_W  = 1,
  parameter int MY_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_excl,
  input  logic [ID_W-1:0] bus_id,
  input  logic            bus_stall,
  input  logic            tag_hit,
  input  line_bits_t      bits,
  input  logic            cpu_lock,
  input  logic [AW-1:0]   lock_addr,
  output logic            snp_hit,
  output logic            snp_stall,
  output logic            upd_en,
  output line_bits_t      upd_bits
);

  logic foreign_req;

  always_comb begin
    foreign_req = bus_valid && (bus_id != ID_W'(MY_ID));
    snp_hit     = foreign_req && tag_hit;
    snp_stall   = snp_hit && bits.exc && cpu_lock && (lock_addr == bus_addr);
    upd_en      = snp_hit && !bus_stall;
    upd_bits    = bus_excl ? LB_INV : LB_SHR;
  end

  // R9: a holder never changes its line while it is holding the requester off
  assert_no_update_while_stalling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> !snp_stall);

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ID_W  = 1,
  parameter int MY_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req_valid,
  input  logic            cpu_req_excl,
  input  logic            cpu_req_we,
  input  logic            tag_hit,
  input  line_bits_t      bits,
  input  logic            conflict,
  input  logic            bus_valid,
  input  logic [ID_W-1:0] bus_id,
  input  logic            bus_stall,
  output logic            cpu_done,
  output logic            req_valid,
  output logic            fill_en,
  output line_bits_t      fill_bits,
  output logic            wr_en
);

  req_st_e st_q, st_d;
  logic    perm_ok, local_hit, granted;

  always_comb begin
    perm_ok   = cpu_req_excl ? bits.exc : (bits.shr | bits.exc);
    local_hit = cpu_req_valid && tag_hit && perm_ok;
    granted   = (st_q == ST_REQ) && bus_valid && (bus_id == ID_W'(MY_ID)) && !bus_stall;

    cpu_done  = (st_q == ST_IDLE) && local_hit && !conflict;
    req_valid = (st_q == ST_REQ);
    fill_en   = granted;
    fill_bits = cpu_req_excl ? LB_EXC : LB_SHR;
    wr_en     = cpu_done && cpu_req_we && cpu_req_excl;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (cpu_req_valid && !local_hit) st_d = ST_REQ;
      ST_REQ:  if (granted)                     st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R3: a bus request only ever starts from a pending local access
  assert_req_from_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cpu_req_valid));

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 32,
  parameter int ID_W  = 1,
  parameter int MY_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req_valid,
  input  logic [AW-1:0]   cpu_req_addr,
  input  logic            cpu_req_excl,
  input  logic            cpu_req_we,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            cpu_lock,
  output logic            cpu_done,
  output logic [DW-1:0]   cpu_rdata,
  output logic            req_valid,
  output logic [AW-1:0]   req_addr,
  output logic            req_excl,
  output logic [ID_W-1:0] req_id,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_excl,
  input  logic [ID_W-1:0] bus_id,
  input  logic            bus_stall,
  input  logic [DW-1:0]   bus_data,
  output logic            snp_hit,
  output logic            snp_stall,
  output logic [DW-1:0]   snp_data
);

  localparam int LINES = 1 << IDX_W;

  // asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic                   cpu_tag_hit, snp_tag_hit;
  line_bits_t             cpu_bits, snp_bits, fill_bits, upd_bits;
  logic [DW-1:0]          cpu_line_data, snp_line_data;
  logic                   fill_en, wr_en, upd_en, conflict;
  logic [2*LINES-1:0]     bits_flat;
  logic [IDX_W-1:0]       cpu_idx, snp_idx;

  assign cpu_idx  = cpu_req_addr[IDX_W-1:0];
  assign snp_idx  = bus_addr[IDX_W-1:0];
  assign conflict = upd_en && (snp_idx == cpu_idx);

  coh_line_array #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_array (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cpu_addr     (cpu_req_addr),
    .cpu_tag_hit  (cpu_tag_hit),
    .cpu_bits     (cpu_bits),
    .cpu_data     (cpu_line_data),
    .fill_en      (fill_en),
    .fill_bits    (fill_bits),
    .fill_data    (bus_data),
    .wr_en        (wr_en),
    .wr_data      (cpu_wdata),
    .snp_addr     (bus_addr),
    .snp_tag_hit  (snp_tag_hit),
    .snp_bits     (snp_bits),
    .snp_data     (snp_line_data),
    .snp_upd_en   (upd_en),
    .snp_upd_bits (upd_bits),
    .bits_flat    (bits_flat)
  );

  coh_snoop_resp #(.AW(AW), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_excl  (bus_excl),
    .bus_id    (bus_id),
    .bus_stall (bus_stall),
    .tag_hit   (snp_tag_hit),
    .bits      (snp_bits),
    .cpu_lock  (cpu_lock),
    .lock_addr (cpu_req_addr),
    .snp_hit   (snp_hit),
    .snp_stall (snp_stall),
    .upd_en    (upd_en),
    .upd_bits  (upd_bits)
  );

  coh_req_fsm #(.ID_W(ID_W), .MY_ID(MY_ID)) u_req (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_excl  (cpu_req_excl),
    .cpu_req_we    (cpu_req_we),
    .tag_hit       (cpu_tag_hit),
    .bits          (cpu_bits),
    .conflict      (conflict),
    .bus_valid     (bus_valid),
    .bus_id        (bus_id),
    .bus_stall     (bus_stall),
    .cpu_done      (cpu_done),
    .req_valid     (req_valid),
    .fill_en       (fill_en),
    .fill_bits     (fill_bits),
    .wr_en         (wr_en)
  );

  assign cpu_rdata = cpu_line_data;
  assign req_addr  = cpu_req_addr;
  assign req_excl  = cpu_req_excl;
  assign req_id    = ID_W'(MY_ID);
  assign snp_data  = snp_hit ? snp_line_data : '0;

  // R6: a granted exclusive fill leaves the line owned exclusively
  assert_fill_owns_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_en && req_excl) |=> (bits_flat[2*$past(cpu_idx) +: 2] == 2'b01));

  // R6: a snooped exclusive request leaves the holder's line invalid
  assert_snoop_excl_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && bus_excl) |=> (bits_flat[2*$past(snp_idx) +: 2] == 2'b00));

  // R5: a snooped shared request leaves the holder with a shared-only copy
  assert_snoop_shared_demotes_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && !bus_excl) |=> (bits_flat[2*$past(snp_idx) +: 2] == 2'b10));

endmodule

// File: tb/snoop_coh_ctrl_tb_top.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;   // 125 MHz

  logic [1:0]    c_valid, c_excl, c_we, c_lock, c_done;
  logic [AW-1:0] c_addr  [2];
  logic [DW-1:0] c_wdata [2];
  logic [DW-1:0] c_rdata [2];
  logic [1:0]    rqv, rqe, sh, st;
  logic [AW-1:0] ra [2];
  logic [0:0]    rid [2];
  logic [DW-1:0] sd [2];

  logic          bus_valid, bus_excl, bus_stall, bus_hit;
  logic [AW-1:0] bus_addr;
  logic [0:0]    bus_id;
  logic [DW-1:0] bus_data;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  // single shared bus, fixed priority to controller 0
  always_comb begin
    bus_valid = rqv[0] | rqv[1];
    bus_addr  = rqv[0] ? ra[0]  : ra[1];
    bus_excl  = rqv[0] ? rqe[0] : rqe[1];
    bus_id    = rqv[0] ? rid[0] : rid[1];
    bus_stall = st[0] | st[1];
    bus_hit   = sh[0] | sh[1];
    bus_data  = bus_hit ? (sd[0] | sd[1]) : mem_val(bus_addr);
  end

  snoop_coh_ctrl #(.MY_ID(0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(c_valid[0]), .cpu_req_addr(c_addr[0]), .cpu_req_excl(c_excl[0]),
    .cpu_req_we(c_we[0]), .cpu_wdata(c_wdata[0]), .cpu_lock(c_lock[0]),
    .cpu_done(c_done[0]), .cpu_rdata(c_rdata[0]),
    .req_valid(rqv[0]), .req_addr(ra[0]), .req_excl(rqe[0]), .req_id(rid[0]),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_excl(bus_excl), .bus_id(bus_id),
    .bus_stall(bus_stall), .bus_data(bus_data),
    .snp_hit(sh[0]), .snp_stall(st[0]), .snp_data(sd[0])
  );

  snoop_coh_ctrl #(.MY_ID(1)) peer_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(c_valid[1]), .cpu_req_addr(c_addr[1]), .cpu_req_excl(c_excl[1]),
    .cpu_req_we(c_we[1]), .cpu_wdata(c_wdata[1]), .cpu_lock(c_lock[1]),
    .cpu_done(c_done[1]), .cpu_rdata(c_rdata[1]),
    .req_valid(rqv[1]), .req_addr(ra[1]), .req_excl(rqe[1]), .req_id(rid[1]),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_excl(bus_excl), .bus_id(bus_id),
    .bus_stall(bus_stall), .bus_data(bus_data),
    .snp_hit(sh[1]), .snp_stall(st[1]), .snp_data(sd[1])
  );

  int n_chk = 0, n_fail = 0;
  int n_grant = 0, n_stall = 0, self_snoop = 0;
  logic g_hit, g_excl;
  logic [0:0] g_id;

  // bus monitor, sampled between edges
  always @(negedge clk) begin
    #3;
    if (bus_valid && !bus_stall) begin
      n_grant++;
      g_hit  = bus_hit;
      g_excl = bus_excl;
      g_id   = bus_id;
    end
    if (bus_valid && bus_stall) n_stall++;
    if (bus_valid && sh[bus_id]) self_snoop++;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one local access; lat = cycles from presentation to cpu_done
  task automatic access(input int w, input logic [AW-1:0] a, input logic ex,
                        input logic we, input logic [DW-1:0] wd,
                        output int lat, output logic [DW-1:0] rd);
    @(negedge clk);
    c_valid[w] = 1'b1; c_addr[w] = a; c_excl[w] = ex; c_we[w] = we; c_wdata[w] = wd;
    lat = 0;
    rd  = '0;
    forever begin
      #2;
      if (c_done[w]) begin
        rd = c_rdata[w];
        break;
      end
      if (lat > 60) begin
        lat = -1;
        break;
      end
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    c_valid[w] = 1'b0; c_we[w] = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R3 no bus request in reset", 32'(rqv), 32'h0);
    chk("R4 no snoop hit in reset",   32'(sh),  32'h0);
    chk("R2 no completion in reset",  32'(c_done), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R3 idle bus after reset", 32'(rqv), 32'h0);
  endtask

  task automatic t_miss_from_memory();
    int lat; logic [DW-1:0] rd;
    access(0, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R3 miss latency", 32'(lat), 32'd2);
    chk("R7 memory data on miss", rd, mem_val(8'h10));
    chk("R7 no cache hit when no holder", 32'(g_hit), 32'h0);
    chk("R3 request type shared", 32'(g_excl), 32'h0);
    chk("R3 request carries id 0", 32'(g_id), 32'h0);
  endtask

  task automatic t_peer_supply();
    int lat, g0; logic [DW-1:0] rd;
    access(1, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R4 holder hit reported", 32'(g_hit), 32'h1);
    chk("R5 shared fill latency", 32'(lat), 32'd2);
    chk("R4 data supplied", rd, mem_val(8'h10));
    g0 = n_grant;
    access(0, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R5 holder keeps shared copy", 32'(lat), 32'd0);
    access(1, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R5 requester installed shared", 32'(lat), 32'd0);
    chk("R2 hits use no bus", 32'(n_grant - g0), 32'd0);
  endtask

  task automatic t_upgrade();
    int lat; logic [DW-1:0] rd;
    access(0, 8'h10, 1'b1, 1'b1, 32'hA1A1_0001, lat, rd);
    chk("R8 upgrade takes bus", 32'(lat), 32'd2);
    chk("R8 upgrade request is exclusive", 32'(g_excl), 32'h1);
    access(1, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R8 sharer was invalidated", 32'(lat), 32'd2);
    chk("R12 written value supplied to peer", rd, 32'hA1A1_0001);
    chk("R4 cache supplies instead of memory", 32'(g_hit), 32'h1);
    access(0, 8'h10, 1'b1, 1'b0, '0, lat, rd);
    chk("R5 holder demoted to shared", 32'(lat), 32'd2);
    access(0, 8'h10, 1'b1, 1'b1, 32'hA1A1_0002, lat, rd);
    chk("R2 exclusive hit in zero cycles", 32'(lat), 32'd0);
    access(0, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R12 local write visible", rd, 32'hA1A1_0002);
  endtask

  task automatic t_steal();
    int lat; logic [DW-1:0] rd;
    access(1, 8'h10, 1'b1, 1'b0, '0, lat, rd);
    chk("R6 exclusive steal latency", 32'(lat), 32'd2);
    chk("R6 owner data moved", rd, 32'hA1A1_0002);
    access(1, 8'h10, 1'b1, 1'b0, '0, lat, rd);
    chk("R6 requester owns line", 32'(lat), 32'd0);
    access(0, 8'h10, 1'b0, 1'b0, '0, lat, rd);
    chk("R6 old holder invalidated", 32'(lat), 32'd2);
    chk("R6 old holder refetches owner copy", rd, 32'hA1A1_0002);
  endtask

  task automatic t_memory_excl();
    int lat; logic [DW-1:0] rd;
    access(1, 8'h23, 1'b1, 1'b0, '0, lat, rd);
    chk("R7 exclusive miss from memory", rd, mem_val(8'h23));
    chk("R7 no holder hit", 32'(g_hit), 32'h0);
    chk("R11 request carries id 1", 32'(g_id), 32'h1);
    access(1, 8'h23, 1'b1, 1'b0, '0, lat, rd);
    chk("R6 memory fill owned exclusively", 32'(lat), 32'd0);
  endtask

  task automatic t_lock_stall();
    int lat, latb; logic [DW-1:0] rd, rdb;
    c_lock[0] = 1'b1;
    access(0, 8'h31, 1'b1, 1'b1, 32'h10C0_0031, lat, rd);
    chk("R9 lock acquire latency", 32'(lat), 32'd2);
    n_stall = 0;
    fork
      access(1, 8'h31, 1'b0, 1'b0, '0, latb, rdb);
      begin
        repeat (6) @(negedge clk);
        c_lock[0] = 1'b0;
      end
    join
    chk("R9 requester held until unlock", 32'(latb), 32'd6);
    chk("R9 stall cycles", 32'(n_stall), 32'd4);
    chk("R9 data after lock", rdb, 32'h10C0_0031);
    access(0, 8'h31, 1'b0, 1'b0, '0, lat, rd);
    chk("R5 lock holder now shared", 32'(lat), 32'd0);
  endtask

  task automatic t_collision();
    int lat_a, lat_b; logic [DW-1:0] rd_a, rd_b;
    access(0, 8'h42, 1'b1, 1'b0, '0, lat_a, rd_a);
    chk("R7 owner fill from memory", rd_a, mem_val(8'h42));
    fork
      access(1, 8'h42, 1'b1, 1'b1, 32'hC0DE_0042, lat_b, rd_b);
      begin
        @(negedge clk);
        access(0, 8'h42, 1'b0, 1'b0, '0, lat_a, rd_a);
      end
    join
    chk("R10 peer exclusive write latency", 32'(lat_b), 32'd2);
    chk("R10 local hit withheld under snoop", 32'(lat_a), 32'd3);
    chk("R10 local read sees snoop winner data", rd_a, 32'hC0DE_0042);
  endtask

  initial begin
    c_valid = '0; c_excl = '0; c_we = '0; c_lock = '0;
    for (int i = 0; i < 2; i++) begin
      c_addr[i] = '0; c_wdata[i] = '0;
    end
    t_reset();
    t_miss_from_memory();
    t_peer_supply();
    t_upgrade();
    t_steal();
    t_memory_excl();
    t_lock_stall();
    t_collision();
    chk("R11 no self-snoop hit", 32'(self_snoop), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule